// File: doc/BRIEF.md
# Self-Configuring Host Bus Front End

This block sits between a small microcontroller and the register file of a peripheral. It works out for itself which kind of host is attached, so no glue logic or strap pins are needed. The first kind of host uses separate active-low read and write strobes. The second uses a direction line plus an active-low data strobe. The block also works out whether the bus is non-multiplexed, with three address pins, or multiplexed, with the low address bits carried on the data lines and captured by an address-latch-enable pulse. Both guesses start from fixed defaults and are refined by the first accesses. The first host read makes them final until the next reset.

From the decoded bus the block produces one-cycle internal register write and read-side-effect strobes, together with their addresses. The read data path is combinational from the raw pins. The read side-effect path can run in an optional high-speed mode. In that mode the address and chip select are captured only once the read has stayed asserted for a number of clock stages. The side effect then fires after a further delay. A brief address glitch at the start of a read therefore cannot clear a clear-on-read register by mistake.

One clear-on-read status register is included so the side-effect path can be observed. The remaining registers are outside the block and supply their read data on a plain input.

Top module: `hbi_host_if`

## Requirements
- R1: After reset the strobe style is separate read/write (`dir_strobe_mode`=0), the bus is multiplexed (`nonmux_mode`=0) and `modes_final`=0.
- R2: If, during the first write access (chip select low with `strb_b` low), `strb_a_n` is also seen low, then the strobe style becomes direction/strobe (`dir_strobe_mode`=1) when chip select rises. Later accesses leave it unchanged.
- R3: If the first write access shows `strb_a_n` high throughout, the style locks to separate read/write. A later access with both strobe pins low does not change it.
- R4: While the modes are not final, `pin_a0` high with chip select low sets `nonmux_mode`=1. Otherwise the bus stays multiplexed.
- R5: A read (chip select low, `strb_a_n` low, `strb_b` high) sets `modes_final`. After that, activity on `pin_a0` no longer changes `nonmux_mode`.
- R6: In multiplexed mode, the register address is `ad_in[2:0]` as captured on clock edges while `pin_a2_ale` is high.
- R7: Each write produces exactly one `reg_wr` pulse in the cycle after the write strobe ends. The pulse carries the address and the data from the last active cycle.
- R8: In direction/strobe style, `strb_b` low means write and `strb_b` high means read. A write is active only while `strb_a_n` is also low, so the direction-only phase produces no pulse.
- R9: While a read is active, `ad_oe`=1. `ad_out` shows the status register when the raw address equals 1, and `ext_rd_data` otherwise. Both are combinational.
- R10: With `hs_rd_en`=0, the cycle after a read begins, `reg_rd` pulses once with the address seen on the first read clock edge.
- R11: With `hs_rd_en`=1, the address is captured after the read has been held `D1_STAGES` cycles. `reg_rd` fires after a further `D2_STAGES` cycles with that captured address. An address that points at the status register only during the first read cycle does not clear it.
- R12: In high-speed mode, the delayed reads drop at once when the read ends. A read shorter than `D1_STAGES` cycles produces no `reg_rd` pulse.
- R13: Status bits set through `diag_set` accumulate. A `reg_rd` to address 1 clears them in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| hs_rd_en | input | 1 | Enables high-speed read side-effect handling |
| cs_n | input | 1 | Active-low chip select |
| strb_a_n | input | 1 | Read strobe or data strobe, active low |
| strb_b | input | 1 | Write strobe (active low) or direction (low = write) |
| pin_a0 | input | 1 | Address bit 0, held low on a multiplexed bus |
| pin_a1 | input | 1 | Address bit 1 |
| pin_a2_ale | input | 1 | Address bit 2, or address latch enable on a multiplexed bus |
| ad_in | input | 8 | Data (and multiplexed address) from the host |
| ext_rd_data | input | 8 | Read data from the other registers |
| diag_set | input | 8 | Per-bit set requests for the status register |
| ad_out | output | 8 | Read data to the host |
| ad_oe | output | 1 | Read data drive enable |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 3 | Write address |
| reg_wr_data | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read side-effect strobe |
| reg_rd_addr | output | 3 | Read side-effect address |
| dir_strobe_mode | output | 1 | 1 when direction/strobe style is detected |
| nonmux_mode | output | 1 | 1 when a non-multiplexed bus is detected |
| modes_final | output | 1 | 1 once the detected modes are frozen |

## Verification
The assertions assume that the host pins are synchronous to `clk` and that chip select returns high between accesses, since the strobe style is only decided on that rising edge. They also assume that `hs_rd_en` does not change in the middle of a read. The bench changes every pin only on falling clock edges and ends each access with all strobes and chip select inactive. It toggles `hs_rd_en` only while the bus is idle. It drives the glitch case as the status-register address for exactly one read cycle, followed by a different address.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic {STB_RDWR = 1'b0, STB_DIRDS = 1'b1} strobe_style_e;

  // Write decode for each strobe style (pin levels as seen at the pins)
  function automatic logic is_write(strobe_style_e sty, logic a_n, logic b);
    if (sty == STB_DIRDS) return !a_n && !b;
    return a_n && !b;
  endfunction

  // A read looks the same in both styles: a/ds low, b (nWR or DIR) high
  function automatic logic is_read(logic a_n, logic b);
    return !a_n && b;
  endfunction
endpackage

// File: rtl/hbi_mode_detect.sv
module hbi_mode_detect
  import hbi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          pin_a_n,
  input  logic          pin_b,
  input  logic          pin_a0,
  output strobe_style_e style,
  output logic          nonmux,
  output logic          final_q
);
  logic cs_q, saw_wr, saw_both, style_lk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      style    <= STB_RDWR;
      nonmux   <= 1'b0;
      final_q  <= 1'b0;
      cs_q     <= 1'b1;
      saw_wr   <= 1'b0;
      saw_both <= 1'b0;
      style_lk <= 1'b0;
    end else begin
      cs_q <= cs_n;
      if (!final_q) begin
        if (!cs_n && is_read(pin_a_n, pin_b)) final_q <= 1'b1;
        if (!cs_n && pin_a0) nonmux <= 1'b1;
        if (!style_lk) begin
          if (!cs_n && !pin_b) begin
            saw_wr <= 1'b1;
            if (!pin_a_n) saw_both <= 1'b1;
          end
          if (cs_n && !cs_q && saw_wr) begin
            style    <= saw_both ? STB_DIRDS : STB_RDWR;
            style_lk <= 1'b1;
          end
        end
      end
    end
  end

  AST_STYLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    style_lk |=> $stable(style)); // R3
  AST_FINAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    final_q |=> final_q); // R5
  AST_FINAL_FREEZES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    final_q |=> $stable(nonmux)); // R5
  AST_NONMUX_FROM_A0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nonmux) |-> $past(pin_a0 && !cs_n)); // R4
endmodule

// File: rtl/hbi_rd_delay.sv
module hbi_rd_delay #(
  parameter int D1_STAGES = 2,
  parameter int D2_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_rd,
  output logic rd_d1,
  output logic rd_d2
);
  localparam int NST = D1_STAGES + D2_STAGES;
  logic [NST-1:0] stg;

  for (genvar i = 0; i < NST; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= 1'b0;
        else        stg[0] <= raw_rd;
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= 1'b0;
        else        stg[i] <= stg[i-1] && raw_rd;
    end
  end

  // Assertion is delayed, release is immediate
  assign rd_d1 = stg[D1_STAGES-1] && raw_rd;
  assign rd_d2 = stg[NST-1] && raw_rd;

  AST_D1_NEEDS_HELD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_d1 |-> $past(raw_rd)); // R12
  AST_D2_AFTER_D1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_d2 |-> $past(rd_d1)); // R11
endmodule

// File: rtl/hbi_diag_reg.sv
module hbi_diag_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_bits,
  input  logic          clr,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= '0;
    else        q <= (clr ? '0 : q) | set_bits;

  AST_DIAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_bits == '0) |=> q == '0); // R13
  AST_DIAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (q & $past(q)) == $past(q)); // R13
endmodule

// File: rtl/hbi_host_if.sv
module hbi_host_if
  import hbi_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int          D1_STAGES = 2,
  parameter int          D2_STAGES = 2,
  parameter logic [2:0]  DIAG_ADDR = 3'd1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_rd_en,
  input  logic          cs_n,
  input  logic          strb_a_n,
  input  logic          strb_b,
  input  logic          pin_a0,
  input  logic          pin_a1,
  input  logic          pin_a2_ale,
  input  logic [DW-1:0] ad_in,
  input  logic [DW-1:0] ext_rd_data,
  input  logic [DW-1:0] diag_set,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          reg_wr,
  output logic [2:0]    reg_wr_addr,
  output logic [DW-1:0] reg_wr_data,
  output logic          reg_rd,
  output logic [2:0]    reg_rd_addr,
  output logic          dir_strobe_mode,
  output logic          nonmux_mode,
  output logic          modes_final
);
  localparam int AW = 3;

  strobe_style_e   style;
  logic            nonmux;
  logic [AW-1:0]   ale_addr, raw_addr, cap_addr, samp_addr, side_addr;
  logic [DW-1:0]   cap_data, diag_q;
  logic            wr_act, rd_act, wr_q, raw_q;
  logic            rd_d1, rd_d2, d1_q, d2_q, samp_cs_n, side_fire;

  hbi_mode_detect u_mode (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .pin_a_n(strb_a_n), .pin_b(strb_b),
    .pin_a0(pin_a0), .style(style), .nonmux(nonmux), .final_q(modes_final)
  );

  assign dir_strobe_mode = (style == STB_DIRDS);
  assign nonmux_mode     = nonmux;

  // Address: direct pins or latched from the shared lines
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    ale_addr <= '0;
    else if (!nonmux && pin_a2_ale) ale_addr <= ad_in[AW-1:0];

  assign raw_addr = nonmux ? {pin_a2_ale, pin_a1, pin_a0} : ale_addr;
  assign wr_act   = !cs_n && is_write(style, strb_a_n, strb_b);
  assign rd_act   = !cs_n && is_read(strb_a_n, strb_b);

  // Write capture; strobe issued when the host write ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0; cap_addr <= '0; cap_data <= '0;
      reg_wr <= 1'b0; reg_wr_addr <= '0; reg_wr_data <= '0;
    end else begin
      wr_q   <= wr_act;
      reg_wr <= wr_q && !wr_act;
      if (wr_act) begin
        cap_addr <= raw_addr;
        cap_data <= ad_in;
      end
      if (wr_q && !wr_act) begin
        reg_wr_addr <= cap_addr;
        reg_wr_data <= cap_data;
      end
    end
  end

  // Read side effects
  hbi_rd_delay #(.D1_STAGES(D1_STAGES), .D2_STAGES(D2_STAGES)) u_dly (
    .clk(clk), .rst_n(rst_n), .raw_rd(rd_act), .rd_d1(rd_d1), .rd_d2(rd_d2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0; d1_q <= 1'b0; d2_q <= 1'b0;
      samp_addr <= '0; samp_cs_n <= 1'b1;
      reg_rd <= 1'b0; reg_rd_addr <= '0;
    end else begin
      raw_q <= rd_act;
      d1_q  <= rd_d1;
      d2_q  <= rd_d2;
      if (rd_d1 && !d1_q) begin
        samp_addr <= raw_addr;
        samp_cs_n <= cs_n;
      end
      reg_rd <= side_fire;
      if (side_fire) reg_rd_addr <= side_addr;
    end
  end

  assign side_fire = hs_rd_en ? (rd_d2 && !d2_q && !samp_cs_n) : (rd_act && !raw_q);
  assign side_addr = hs_rd_en ? samp_addr : raw_addr;

  hbi_diag_reg #(.DW(DW)) u_diag (
    .clk(clk), .rst_n(rst_n), .set_bits(diag_set),
    .clr(reg_rd && reg_rd_addr == DIAG_ADDR), .q(diag_q)
  );

  // Read data uses raw pins only
  assign ad_oe  = rd_act;
  assign ad_out = (raw_addr == DIAG_ADDR) ? diag_q : ext_rd_data;

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr); // R7
  AST_RD_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> $past(ad_oe)); // R10
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd); // R10
endmodule

// File: tb/hbi_host_if_tb.sv
module hbi_host_if_tb;
  localparam int CLK_P = 10;
  localparam logic [7:0] EXT = 8'hE7;

  logic clk = 0, rst_n = 0, hs_rd_en = 0;
  logic cs_n = 1, strb_a_n = 1, strb_b = 1, pin_a0 = 0, pin_a1 = 0, pin_a2_ale = 0;
  logic [7:0] ad_in = '0, diag_set = '0;
  logic [7:0] ad_out, reg_wr_data;
  logic ad_oe, reg_wr, reg_rd, dir_strobe_mode, nonmux_mode, modes_final;
  logic [2:0] reg_wr_addr, reg_rd_addr;

  int checks = 0, failures = 0, rd_cnt = 0;
  logic [2:0] last_rd_addr = '0;
  logic mux_bus = 1, done = 0;
  logic [10:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  hbi_host_if u_dut (
    .clk(clk), .rst_n(rst_n), .hs_rd_en(hs_rd_en), .cs_n(cs_n), .strb_a_n(strb_a_n),
    .strb_b(strb_b), .pin_a0(pin_a0), .pin_a1(pin_a1), .pin_a2_ale(pin_a2_ale),
    .ad_in(ad_in), .ext_rd_data(EXT), .diag_set(diag_set), .ad_out(ad_out),
    .ad_oe(ad_oe), .reg_wr(reg_wr), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd(reg_rd), .reg_rd_addr(reg_rd_addr),
    .dir_strobe_mode(dir_strobe_mode), .nonmux_mode(nonmux_mode),
    .modes_final(modes_final)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected writes, tracks read side effects
  always @(negedge clk) if (rst_n) begin
    if (reg_wr) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R7 actual=%0h expected=none", {reg_wr_addr, reg_wr_data});
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        if ({reg_wr_addr, reg_wr_data} != e) begin
          failures++;
          $display("FAIL R7 actual=%0h expected=%0h", {reg_wr_addr, reg_wr_data}, e);
        end
      end
    end
    if (reg_rd) begin
      rd_cnt++;
      last_rd_addr = reg_rd_addr;
    end
  end

  task automatic idle();
    cs_n = 1; strb_a_n = 1; strb_b = 1; pin_a0 = 0;
  endtask

  task automatic set_addr(input logic [2:0] a);
    if (!mux_bus) {pin_a2_ale, pin_a1, pin_a0} = a;
  endtask

  task automatic ale_phase(input logic [2:0] a);
    if (mux_bus) begin
      @(negedge clk); pin_a2_ale = 1; ad_in = {5'b0, a};
      @(negedge clk); pin_a2_ale = 0;
    end
  endtask

  // style: 0 = rd/wr strobes, 1 = dir/ds; dir_first drives direction one cycle early
  task automatic do_write(input logic sty, input logic dir_first, input logic [2:0] a,
                          input logic [7:0] d, input logic expect_pulse);
    ale_phase(a);
    @(negedge clk); set_addr(a); ad_in = d; cs_n = 0; strb_b = 0;
    if (sty) begin
      if (dir_first) @(negedge clk);
      strb_a_n = 0;
    end
    repeat (2) @(negedge clk);
    idle();
    if (expect_pulse) exp_q.push_back({a, d});
    repeat (4) @(negedge clk);
  endtask

  task automatic do_read(input logic [2:0] a_first, input logic [2:0] a_main, input int len,
                         output logic [7:0] d, output logic oe);
    ale_phase(a_main);
    @(negedge clk); set_addr(a_first); cs_n = 0; strb_a_n = 0; strb_b = 1;
    #(CLK_P/4); d = ad_out; oe = ad_oe;
    if (len > 1) begin
      @(negedge clk); set_addr(a_main);
      repeat (len - 2) @(negedge clk);
    end
    @(negedge clk); idle();
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_set(input logic [7:0] v);
    @(negedge clk); diag_set = v;
    @(negedge clk); diag_set = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; idle(); hs_rd_en = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    logic oe;
    int base;
    // ---------------- Multiplexed bus, rd/wr strobes ----------------
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1 style", dir_strobe_mode, 0);
    chk("R1 bus", nonmux_mode, 0);
    chk("R1 final", modes_final, 0);
    pulse_set(8'h5A);
    pulse_set(8'h01);                                   // R13 accumulate
    do_write(0, 0, 3'd5, 8'hC3, 1);                     // R6 R7
    chk("R3 style rw", dir_strobe_mode, 0);
    @(negedge clk); cs_n = 0; strb_a_n = 0; strb_b = 0; // both low after lock
    repeat (2) @(negedge clk); idle(); repeat (3) @(negedge clk);
    chk("R3 style kept", dir_strobe_mode, 0);
    chk("R4 still mux", nonmux_mode, 0);
    base = rd_cnt;
    do_read(3'd1, 3'd1, 3, d, oe);
    chk("R9 oe", oe, 1);
    chk("R9 diag data", d, 8'h5B);
    chk("R5 final", modes_final, 1);
    chk("R10 rd count", rd_cnt - base, 1);
    chk("R10 rd addr", last_rd_addr, 1);
    do_read(3'd1, 3'd1, 3, d, oe);
    chk("R13 cleared", d, 0);
    do_read(3'd4, 3'd4, 2, d, oe);
    chk("R9 ext data", d, EXT);
    @(negedge clk); cs_n = 0; pin_a0 = 1;
    repeat (2) @(negedge clk); idle(); repeat (3) @(negedge clk);
    chk("R5 bus frozen", nonmux_mode, 0);
    chk("R7 queue empty", exp_q.size(), 0);

    // ---------------- Non-multiplexed bus, dir/ds strobes ----------------
    do_reset();
    mux_bus = 0;
    chk("R1 style after reset", dir_strobe_mode, 0);
    do_write(1, 0, 3'd3, 8'h77, 0);                     // detection write
    chk("R2 style ds", dir_strobe_mode, 1);
    chk("R4 nonmux", nonmux_mode, 1);
    do_write(1, 1, 3'd6, 8'h9D, 1);                     // R8 direction first
    @(negedge clk); set_addr(3'd2); cs_n = 0; strb_b = 0; // DIR low, DS high
    repeat (2) @(negedge clk); idle(); repeat (3) @(negedge clk);
    chk("R2 style kept", dir_strobe_mode, 1);
    do_read(3'd2, 3'd2, 2, d, oe);
    chk("R8 read oe", oe, 1);
    chk("R8 read data", d, EXT);
    chk("R5 final ds", modes_final, 1);

    pulse_set(8'h3C);
    @(negedge clk); hs_rd_en = 1;
    base = rd_cnt;
    do_read(3'd1, 3'd3, 8, d, oe);                      // glitch on first cycle
    chk("R11 rd count", rd_cnt - base, 1);
    chk("R11 sampled addr", last_rd_addr, 3);
    do_read(3'd1, 3'd1, 8, d, oe);
    chk("R11 diag intact", d, 8'h3C);
    chk("R11 rd addr diag", last_rd_addr, 1);
    do_read(3'd1, 3'd1, 8, d, oe);
    chk("R13 cleared hs", d, 0);
    pulse_set(8'h11);
    base = rd_cnt;
    do_read(3'd1, 3'd1, 1, d, oe);                      // shorter than D1
    chk("R12 no pulse", rd_cnt - base, 0);
    do_read(3'd1, 3'd1, 1, d, oe);
    chk("R12 diag kept", d, 8'h11);
    @(negedge clk); hs_rd_en = 0;
    do_read(3'd1, 3'd3, 4, d, oe);                      // same glitch, slow path
    chk("R10 glitch addr", last_rd_addr, 1);
    do_read(3'd3, 3'd1, 2, d, oe);
    do_read(3'd1, 3'd1, 1, d, oe);
    chk("R10 glitch cleared", d, 0);
    chk("R7 queue empty ds", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule